// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by reading a page directory entry and then a page table entry from memory through a single 32-bit master port. A request carries the linear address, a write flag, a code/data flag and a user-mode flag. The directory location comes from a 20-bit frame number held in a base input, sampled when the request is taken. With paging turned off the block returns the linear address unchanged and never touches memory.

While walking, the block checks the present bit at each level and stops with a page fault (error code 0) when it is clear. If an entry's accessed bit is clear, the walker writes the entry back with that bit set, to the address it was read from, before going on. When both levels are present, the writable and user bits of the two entries are ANDed and checked against the request. A walk that passes yields the physical address and a one-cycle fill pulse toward a translation cache. A walk that fails yields a protection fault with an error code. Only one walk is in flight at a time.

Top module: `ptw_top`

## Requirements
- R1: When `paging_en` is low at acceptance, the response carries `rsp_paddr` equal to the request address and no fault, and the block issues no memory transaction.
- R2: The directory entry is read at `{dir_base_frame, laddr[31:22], 2'b00}`. The table entry is read at `{dir_entry[31:12], laddr[21:12], 2'b00}`.
- R3: In an entry, bit 0 means present, bit 1 writable, bit 2 user and bit 5 accessed. A clear present bit at either level ends the walk with `rsp_fault` set and `rsp_err` equal to 0. No further memory access follows.
- R4: An entry whose accessed bit is clear is written back with bit 5 set, to the address it was read from, before the walk goes on. An entry with the bit already set causes no write.
- R5: A successful walk returns `{table_entry[31:12], laddr[11:0]}` as the physical address, with `rsp_err` equal to 0.
- R6: The effective writable and user bits are the AND of the two entries. A user access with effective user clear faults. A user write with effective writable clear faults. A supervisor access never raises a protection fault.
- R7: On a protection fault, `rsp_err` bit 0 is 1, bit 1 equals the write flag and bit 2 equals the user flag. A response without a fault has `rsp_err` equal to 0.
- R8: A successful paged walk pulses `fill_valid` in the response cycle. The pulse carries the linear address, the table entry with the accessed bit set, and the code flag. A fault or a bypass produces no fill.
- R9: `req_ready` goes low the cycle after a request is accepted and stays low until the response. `rsp_valid` is a one-cycle pulse.
- R10: A memory request holds its valid, address and write flag until `mem_req_ready` is high. Read data arrives on `mem_rsp_valid` in a later cycle, and writes need no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, can take a request |
| req_laddr | input | 32 | Linear address |
| req_write | input | 1 | Access is a write |
| req_code | input | 1 | Access is an instruction fetch |
| req_user | input | 1 | Access is made in user mode |
| paging_en | input | 1 | Paging turned on |
| dir_base_frame | input | 20 | Frame number of the page directory |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | Memory request is a write |
| mem_req_addr | output | 32 | Memory byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| rsp_valid | output | 1 | Translation result pulse |
| rsp_fault | output | 1 | Page fault |
| rsp_err | output | 3 | Fault error code |
| rsp_paddr | output | 32 | Physical address |
| fill_valid | output | 1 | Translation cache fill pulse |
| fill_laddr | output | 32 | Linear address to cache |
| fill_entry | output | 32 | Table entry to cache |
| fill_code | output | 1 | Fill came from a code access |

## Verification
The bench tests a permission that one level grants and the other denies. A walker that ORs the levels, or checks only the table entry, would let such an access through. It runs entries with the accessed bit clear at one or both levels and counts the writes and where they land. A walker that skips the write-back, or writes to the wrong slot, would leave memory unchanged or touch the wrong word. It combines a missing-access-bit write-back with a protection fault to show the write-back happens before the check. It uses the first and last directory and table slots to catch index slicing errors. It stalls `mem_req_ready` on alternate cycles, which shows up a walker that lets a request drop or change before it is accepted.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int unsigned ADDR_W   = 32;
    localparam int unsigned FRAME_W  = 20;
    localparam int unsigned IDX_W    = 10;
    localparam int unsigned OFF_W    = ADDR_W - FRAME_W;
    localparam int unsigned ERR_W    = 3;

    // entry flag positions
    localparam int unsigned BIT_PRESENT  = 0;
    localparam int unsigned BIT_WRITABLE = 1;
    localparam int unsigned BIT_USER     = 2;
    localparam int unsigned BIT_ACCESSED = 5;

    localparam logic [ADDR_W-1:0] ACC_MASK = ADDR_W'(1) << BIT_ACCESSED;

    typedef struct packed {
        logic [ADDR_W-1:0] laddr;
        logic              write;
        logic              code;
        logic              user;
    } walk_req_t;

    typedef struct packed {
        logic              fault;
        logic [ERR_W-1:0]  err;
        logic [ADDR_W-1:0] paddr;
    } walk_rsp_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_RD,
        ST_DIR_WAIT,
        ST_DIR_WB,
        ST_TBL_RD,
        ST_TBL_WAIT,
        ST_TBL_WB,
        ST_FINISH
    } walk_state_t;

    // byte address of a 4-byte slot inside a page-sized table
    function automatic logic [ADDR_W-1:0] slot_addr(input logic [FRAME_W-1:0] frame,
                                                    input logic [IDX_W-1:0]   idx);
        return {frame, idx, 2'b00};
    endfunction

endpackage

// File: rtl/ptw_perm.sv
module ptw_perm
    import ptw_pkg::*;
(
    input  logic             dir_w,
    input  logic             dir_u,
    input  logic             tbl_w,
    input  logic             tbl_u,
    input  logic             acc_write,
    input  logic             acc_user,
    output logic             allow,
    output logic [ERR_W-1:0] err
);
    logic eff_w;
    logic eff_u;

    always_comb begin
        eff_w = dir_w & tbl_w;
        eff_u = dir_u & tbl_u;
        allow = !(acc_user && (!eff_u || (acc_write && !eff_w)));
        err   = {acc_user, acc_write, 1'b1};
    end

endmodule

// File: rtl/ptw_walk.sv
module ptw_walk
    import ptw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  walk_req_t          req_in,
    input  logic               paging_en,
    input  logic [FRAME_W-1:0] base_frame,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic               mem_req_write,
    output logic [ADDR_W-1:0]  mem_req_addr,
    output logic [ADDR_W-1:0]  mem_req_wdata,
    input  logic               mem_rsp_valid,
    input  logic [ADDR_W-1:0]  mem_rsp_data,
    output logic [ADDR_W-1:0]  dir_entry,
    output logic [ADDR_W-1:0]  tbl_entry,
    output logic               walk_write,
    output logic               walk_user,
    input  logic               perm_ok,
    input  logic [ERR_W-1:0]   perm_err,
    output logic               rsp_valid,
    output walk_rsp_t          rsp,
    output logic               fill_valid,
    output logic [ADDR_W-1:0]  fill_laddr,
    output logic [ADDR_W-1:0]  fill_entry,
    output logic               fill_code
);
    walk_state_t        state_q;
    walk_req_t          cur_q;
    logic               bypass_q;
    logic [FRAME_W-1:0] base_q;
    logic [ADDR_W-1:0]  dir_q;
    logic [ADDR_W-1:0]  tbl_q;
    logic               got_present;
    logic               got_accessed;

    assign got_present  = mem_rsp_data[BIT_PRESENT];
    assign got_accessed = mem_rsp_data[BIT_ACCESSED];
    assign req_ready    = (state_q == ST_IDLE);
    assign dir_entry    = dir_q;
    assign tbl_entry    = tbl_q;
    assign walk_write   = cur_q.write;
    assign walk_user    = cur_q.user;

    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = '0;
        mem_req_wdata = '0;
        case (state_q)
            ST_DIR_RD, ST_DIR_WB: begin
                mem_req_valid = 1'b1;
                mem_req_write = (state_q == ST_DIR_WB);
                mem_req_addr  = slot_addr(base_q, cur_q.laddr[ADDR_W-1 -: IDX_W]);
                mem_req_wdata = dir_q;
            end
            ST_TBL_RD, ST_TBL_WB: begin
                mem_req_valid = 1'b1;
                mem_req_write = (state_q == ST_TBL_WB);
                mem_req_addr  = slot_addr(dir_q[ADDR_W-1 -: FRAME_W],
                                          cur_q.laddr[OFF_W +: IDX_W]);
                mem_req_wdata = tbl_q;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            cur_q      <= '0;
            bypass_q   <= 1'b0;
            base_q     <= '0;
            dir_q      <= '0;
            tbl_q      <= '0;
            rsp_valid  <= 1'b0;
            rsp        <= '0;
            fill_valid <= 1'b0;
            fill_laddr <= '0;
            fill_entry <= '0;
            fill_code  <= 1'b0;
        end else begin
            rsp_valid  <= 1'b0;
            fill_valid <= 1'b0;
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    cur_q    <= req_in;
                    base_q   <= base_frame;
                    bypass_q <= !paging_en;
                    state_q  <= paging_en ? ST_DIR_RD : ST_FINISH;
                end
                ST_DIR_RD: if (mem_req_ready) state_q <= ST_DIR_WAIT;
                ST_DIR_WAIT: if (mem_rsp_valid) begin
                    dir_q <= mem_rsp_data | ACC_MASK;
                    if (!got_present) begin
                        rsp_valid <= 1'b1;
                        rsp       <= '{fault: 1'b1, err: '0, paddr: '0};
                        state_q   <= ST_IDLE;
                    end else begin
                        state_q <= got_accessed ? ST_TBL_RD : ST_DIR_WB;
                    end
                end
                ST_DIR_WB: if (mem_req_ready) state_q <= ST_TBL_RD;
                ST_TBL_RD: if (mem_req_ready) state_q <= ST_TBL_WAIT;
                ST_TBL_WAIT: if (mem_rsp_valid) begin
                    tbl_q <= mem_rsp_data | ACC_MASK;
                    if (!got_present) begin
                        rsp_valid <= 1'b1;
                        rsp       <= '{fault: 1'b1, err: '0, paddr: '0};
                        state_q   <= ST_IDLE;
                    end else begin
                        state_q <= got_accessed ? ST_FINISH : ST_TBL_WB;
                    end
                end
                ST_TBL_WB: if (mem_req_ready) state_q <= ST_FINISH;
                ST_FINISH: begin
                    rsp_valid <= 1'b1;
                    state_q   <= ST_IDLE;
                    if (bypass_q) begin
                        rsp <= '{fault: 1'b0, err: '0, paddr: cur_q.laddr};
                    end else if (!perm_ok) begin
                        rsp <= '{fault: 1'b1, err: perm_err, paddr: '0};
                    end else begin
                        rsp <= '{fault: 1'b0, err: '0,
                                 paddr: {tbl_q[ADDR_W-1 -: FRAME_W], cur_q.laddr[OFF_W-1:0]}};
                        fill_valid <= 1'b1;
                        fill_laddr <= cur_q.laddr;
                        fill_entry <= tbl_q;
                        fill_code  <= cur_q.code;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // checker state: address of the most recent accepted read
    logic [ADDR_W-1:0] last_rd_q;
    always_ff @(posedge clk) begin
        if (rst) last_rd_q <= '0;
        else if (mem_req_valid && mem_req_ready && !mem_req_write) last_rd_q <= mem_req_addr;
    end

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)); // R10
    AST_WB_SAME_SLOT: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && mem_req_write |-> mem_req_addr == last_rd_q); // R4
    AST_BYPASS_NO_MEM: assert property (@(posedge clk) disable iff (rst)
        bypass_q && state_q != ST_IDLE |-> !mem_req_valid); // R1
    AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> !req_ready); // R9
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R9
    AST_FILL_ON_SUCCESS: assert property (@(posedge clk) disable iff (rst)
        fill_valid |-> rsp_valid && !rsp.fault); // R8
    AST_OK_ERR_ZERO: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp.fault |-> rsp.err == '0); // R7

endmodule

// File: rtl/ptw_top.sv
module ptw_top
    import ptw_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         req_valid,
    output logic         req_ready,
    input  logic [31:0]  req_laddr,
    input  logic         req_write,
    input  logic         req_code,
    input  logic         req_user,
    input  logic         paging_en,
    input  logic [19:0]  dir_base_frame,
    output logic         mem_req_valid,
    input  logic         mem_req_ready,
    output logic         mem_req_write,
    output logic [31:0]  mem_req_addr,
    output logic [31:0]  mem_req_wdata,
    input  logic         mem_rsp_valid,
    input  logic [31:0]  mem_rsp_data,
    output logic         rsp_valid,
    output logic         rsp_fault,
    output logic [2:0]   rsp_err,
    output logic [31:0]  rsp_paddr,
    output logic         fill_valid,
    output logic [31:0]  fill_laddr,
    output logic [31:0]  fill_entry,
    output logic         fill_code
);
    walk_req_t         req_s;
    walk_rsp_t         rsp_s;
    logic [ADDR_W-1:0] dir_e;
    logic [ADDR_W-1:0] tbl_e;
    logic              w_write;
    logic              w_user;
    logic              ok;
    logic [ERR_W-1:0]  perr;

    assign req_s = '{laddr: req_laddr, write: req_write, code: req_code, user: req_user};

    ptw_walk u_walk (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_in        (req_s),
        .paging_en     (paging_en),
        .base_frame    (dir_base_frame),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_write (mem_req_write),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .dir_entry     (dir_e),
        .tbl_entry     (tbl_e),
        .walk_write    (w_write),
        .walk_user     (w_user),
        .perm_ok       (ok),
        .perm_err      (perr),
        .rsp_valid     (rsp_valid),
        .rsp           (rsp_s),
        .fill_valid    (fill_valid),
        .fill_laddr    (fill_laddr),
        .fill_entry    (fill_entry),
        .fill_code     (fill_code)
    );

    ptw_perm u_perm (
        .dir_w     (dir_e[BIT_WRITABLE]),
        .dir_u     (dir_e[BIT_USER]),
        .tbl_w     (tbl_e[BIT_WRITABLE]),
        .tbl_u     (tbl_e[BIT_USER]),
        .acc_write (w_write),
        .acc_user  (w_user),
        .allow     (ok),
        .err       (perr)
    );

    assign rsp_fault = rsp_s.fault;
    assign rsp_err   = rsp_s.err;
    assign rsp_paddr = rsp_s.paddr;

endmodule

// File: tb/tb_ptw_top.sv
module tb_ptw_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [19:0] BASE = 20'h00010;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready, req_write, req_code, req_user, paging_en;
    logic [31:0] req_laddr;
    logic        mem_req_valid, mem_req_ready, mem_req_write;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        rsp_valid, rsp_fault, fill_valid, fill_code;
    logic [2:0]  rsp_err;
    logic [31:0] rsp_paddr, fill_laddr, fill_entry;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptw_top dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr),
        .req_write(req_write), .req_code(req_code), .req_user(req_user),
        .paging_en(paging_en), .dir_base_frame(BASE),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_err(rsp_err),
        .rsp_paddr(rsp_paddr), .fill_valid(fill_valid), .fill_laddr(fill_laddr),
        .fill_entry(fill_entry), .fill_code(fill_code)
    );

    // memory model
    logic [31:0] mem [logic [31:0]];
    int unsigned tick = 0;
    int          n_rd, n_wr;
    logic        stall_mode = 1'b0;
    assign mem_req_ready = stall_mode ? tick[0] : 1'b1;

    always @(posedge clk) begin
        tick <= tick + 1;
        mem_rsp_valid <= 1'b0;
        if (!rst && mem_req_valid && mem_req_ready) begin
            if (mem_req_write) begin
                mem[mem_req_addr] = mem_req_wdata;
                n_wr = n_wr + 1;
            end else begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= mem.exists(mem_req_addr) ? mem[mem_req_addr] : 32'h0;
                n_rd = n_rd + 1;
            end
        end
    end

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_bad++;
                $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    typedef struct packed {
        logic [31:0] la;
        logic        wr;
        logic        usr;
        logic [31:0] pde;
        logic [31:0] pte;
        logic        flt;
        logic [2:0]  err;
        logic [31:0] pa;
        logic [3:0]  nrd;
        logic [3:0]  nwr;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{32'h12345678, 1'b0, 1'b0, 32'h00020027, 32'hABCDE027, 1'b0, 3'd0, 32'hABCDE678, 4'd2, 4'd0}, // R5
        '{32'h12345678, 1'b0, 1'b0, 32'h00020007, 32'hABCDE007, 1'b0, 3'd0, 32'hABCDE678, 4'd2, 4'd2}, // R4
        '{32'h12345678, 1'b0, 1'b0, 32'h00020026, 32'hABCDE027, 1'b1, 3'd0, 32'h0,        4'd1, 4'd0}, // R3 dir
        '{32'h12345678, 1'b1, 1'b1, 32'h00020027, 32'hABCDE026, 1'b1, 3'd0, 32'h0,        4'd2, 4'd0}, // R3 tbl
        '{32'h12345678, 1'b0, 1'b1, 32'h00020027, 32'hABCDE023, 1'b1, 3'd5, 32'h0,        4'd2, 4'd0}, // R6
        '{32'h12345678, 1'b1, 1'b1, 32'h00020025, 32'hABCDE027, 1'b1, 3'd7, 32'h0,        4'd2, 4'd0}, // R6
        '{32'h12345678, 1'b1, 1'b1, 32'h00020027, 32'hABCDE027, 1'b0, 3'd0, 32'hABCDE678, 4'd2, 4'd0}, // R6
        '{32'h12345678, 1'b1, 1'b0, 32'h00020025, 32'hABCDE025, 1'b0, 3'd0, 32'hABCDE678, 4'd2, 4'd0}, // R6 supervisor
        '{32'h12345678, 1'b0, 1'b1, 32'h00020023, 32'hABCDE027, 1'b1, 3'd5, 32'h0,        4'd2, 4'd0}, // R6 AND
        '{32'h12345678, 1'b1, 1'b1, 32'h00020027, 32'hABCDE003, 1'b1, 3'd7, 32'h0,        4'd2, 4'd1}, // R4+R7
        '{32'hFFFFF000, 1'b0, 1'b0, 32'h00020027, 32'h00001027, 1'b0, 3'd0, 32'h00001000, 4'd2, 4'd0}, // R2 top slots
        '{32'h00000FFF, 1'b1, 1'b1, 32'h00020007, 32'hABC00007, 1'b0, 3'd0, 32'hABC00FFF, 4'd2, 4'd2}  // R2 bottom slots
    };

    logic        g_flt, g_fill, g_fcode;
    logic [2:0]  g_err;
    logic [31:0] g_pa, g_fla, g_fent;
    logic        g_busy;

    task automatic walk(input logic [31:0] la, input logic wr, input logic usr,
                        input logic code, input logic pg);
        @(negedge clk);
        n_rd = 0; n_wr = 0;
        req_valid = 1'b1; req_laddr = la; req_write = wr; req_user = usr;
        req_code = code; paging_en = pg;
        @(negedge clk);
        req_valid = 1'b0;
        g_busy = req_ready;
        for (int k = 0; k < 200; k++) begin
            if (rsp_valid) break;
            @(negedge clk);
        end
        g_flt = rsp_fault; g_err = rsp_err; g_pa = rsp_paddr;
        g_fill = fill_valid; g_fla = fill_laddr; g_fent = fill_entry; g_fcode = fill_code;
        chk(rsp_valid, "R9 response seen", {31'd0, rsp_valid}, 32'd1);
        @(negedge clk);
        chk(!rsp_valid, "R9 response is one pulse", {31'd0, rsp_valid}, 32'd0);
    endtask

    task automatic run_vec(input vec_t v, input logic code);
        logic [31:0] pde_a, pte_a;
        pde_a = {BASE, v.la[31:22], 2'b00};
        pte_a = {v.pde[31:12], v.la[21:12], 2'b00};
        mem.delete();
        mem[pde_a] = v.pde;
        mem[pte_a] = v.pte;
        walk(v.la, v.wr, v.usr, code, 1'b1);
        chk(!g_busy, "R9 busy after accept", {31'd0, g_busy}, 32'd0);
        chk(g_flt == v.flt, "R3/R6 fault flag", {31'd0, g_flt}, {31'd0, v.flt});
        chk(g_err == v.err, "R3/R7 error code", {29'd0, g_err}, {29'd0, v.err});
        chk(g_pa == v.pa, "R2/R5 physical address", g_pa, v.pa);
        chk(n_rd == int'(v.nrd), "R3 read count", n_rd, {28'd0, v.nrd});
        chk(n_wr == int'(v.nwr), "R4 write count", n_wr, {28'd0, v.nwr});
        chk(g_fill == !v.flt, "R8 fill pulse", {31'd0, g_fill}, {31'd0, !v.flt});
        if (!v.flt) begin
            chk(g_fla == v.la, "R8 fill address", g_fla, v.la);
            chk(g_fent == (v.pte | 32'h20), "R8 fill entry", g_fent, v.pte | 32'h20);
            chk(g_fcode == code, "R8 fill code flag", {31'd0, g_fcode}, {31'd0, code});
        end
        if (v.nrd == 4'd2)
            chk(mem[pde_a][5], "R4 dir accessed bit in memory", mem[pde_a], v.pde | 32'h20);
        if (v.nwr != 4'd0 && v.pte[0])
            chk(mem[pte_a] == (v.pte | 32'h20), "R4 table slot written back", mem[pte_a], v.pte | 32'h20);
    endtask

    initial begin
        rst = 1'b1;
        req_valid = 1'b0; req_laddr = '0; req_write = 1'b0; req_code = 1'b0;
        req_user = 1'b0; paging_en = 1'b0;
        n_rd = 0; n_wr = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready, "R9 idle after reset", {31'd0, req_ready}, 32'd1);
        chk(!rsp_valid && !fill_valid, "R9 no response after reset", {30'd0, rsp_valid, fill_valid}, 32'd0);
        chk(!mem_req_valid, "R10 no memory request after reset", {31'd0, mem_req_valid}, 32'd0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], i[0]);

        // R1: bypass with paging off, memory is loaded but must stay untouched
        walk(32'hDEADBEEF, 1'b1, 1'b1, 1'b0, 1'b0);
        chk(!g_flt, "R1 bypass no fault", {31'd0, g_flt}, 32'd0);
        chk(g_pa == 32'hDEADBEEF, "R1 bypass address", g_pa, 32'hDEADBEEF);
        chk(n_rd == 0 && n_wr == 0, "R1 bypass memory idle", n_rd + n_wr, 32'd0);
        chk(!g_fill, "R8 no fill on bypass", {31'd0, g_fill}, 32'd0);

        // R10: stalled memory port
        stall_mode = 1'b1;
        run_vec(VECS[1], 1'b1);
        run_vec(VECS[11], 1'b0);
        run_vec(VECS[9], 1'b1);
        stall_mode = 1'b0;
        chk(req_ready, "R10 idle after stalled walks", {31'd0, req_ready}, 32'd1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule